// File: doc/BRIEF.md
# Preamble-Locked Manchester Bit Recovery

This block turns a single-wire, Manchester-coded serial line into a stream of decoded data bits. The line is sampled once per system clock, and the clock runs at a fixed multiple of the bit rate (eight by default). Every coded bit carries a transition at its centre. In the normal sense of the line, a logic 1 is sent as a low half followed by a high half, and a logic 0 as a high half followed by a low half. The block treats the centre transitions as its timing reference and ignores the transitions that fall on bit boundaries.

A frame opens with a preamble of alternating bits 0,1,0,1,… In the preamble every transition is a centre transition, spaced one bit apart, so the block can find bit phase wherever it joins the stream. Once it has phase lock, it tracks the decoded preamble bits until two equal bits arrive in a row. That pair ends the preamble. A pair of 1s means the line has its normal sense. A pair of 0s means the two wires were swapped, so the block raises its polarity flag and complements every bit that follows.

Payload bits leave on a valid/ready port. A bit is held with `out_valid` high until `out_ready` accepts it. With `out_ready` tied high, each bit appears as a one-cycle pulse. The sink must accept each bit before the next one is decoded, which is within one bit period (`OSR` clocks). A bit that is still unaccepted when the next bit is decoded is replaced by the new bit. Loss of lock and reset both return the block to preamble search.

Top module: `mdec_rx`

## Requirements
- R1: `locked` rises only after eight consecutive line transitions whose spacing is `OSR`-1 to `OSR`+1 samples (7 to 9 by default). A preamble of only seven bits, or one whose transitions are 6 or 10 samples apart, never sets `locked`.
- R2: A stream whose bit period is 7 or 9 samples decodes as correctly as one at 8 samples.
- R3: Each decoded bit is the line level taken `OSR`/4 samples after the accepted centre transition: high gives 1 and low gives 0, before any polarity correction. So, on a line of normal sense, 0 is coded high-then-low and 1 is coded low-then-high.
- R4: Preamble bits and the two terminator bits are never output. Every bit after the terminator is output once, in line order.
- R5: A terminator that decodes as 0,0 sets `inverted` and complements every payload bit. A terminator of 1,1 leaves `inverted` low.
- R6: While locked, transitions that fall outside the centre window (such as the boundary transition between two equal bits) are ignored and do not disturb bit timing.
- R7: When no centre transition has been accepted for `OSR`+12 samples (20 by default), `locked` and `inverted` clear on the same clock edge, and the next frame is acquired afresh. Both flags stay steady through a payload.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` does not change. A bit is transferred on each clock edge where both are high.
- R9: Synchronous active-high `rst` clears `locked`, `inverted` and `out_valid`, even in the middle of a frame.
- R10: `out_valid` rises only while the block is locked. A stream that never reaches lock produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one line sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Manchester line, already synchronized to `clk` |
| out_ready | input | 1 | Sink can take the held bit |
| out_valid | output | 1 | A decoded payload bit is held on `out_bit` |
| out_bit | output | 1 | Decoded payload bit, polarity corrected |
| locked | output | 1 | Bit phase is locked |
| inverted | output | 1 | Terminator showed a swapped line |

## Verification
The holding check assumes that the sink never leaves `out_ready` low for a whole bit period. If it did, the next decoded bit would legally replace the held one. The stimulus therefore lowers `out_ready` at random, but never for more than three clocks in a row. The timing checks assume that frames are separated by more idle time than the loss window and that line bits are 7 to 9 samples long. Accordingly, every frame starts and ends with an idle gap longer than 20 samples, and the stream tests outside that range only in frames that are meant to fail to lock.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Framing state after phase lock: tracking preamble, or passing payload.
  typedef enum logic [0:0] {
    FR_PREAMBLE = 1'b0,
    FR_PAYLOAD  = 1'b1
  } mdec_frame_t;

  // Per-cycle events from the phase tracker to the framer.
  typedef struct packed {
    logic sample;  // take the line level now (quarter bit after centre)
    logic drop;    // lock is being released at this edge
  } mdec_tick_t;

endpackage

// File: rtl/mdec_edge.sv
module mdec_edge (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic level,
  output logic toggled
);

  logic cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= line_in;
      prev_q <= cur_q;
    end
  end

  assign level   = cur_q;
  assign toggled = cur_q ^ prev_q;

endmodule

// File: rtl/mdec_phase.sv
module mdec_phase
  import mdec_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int TOL      = 1,
  parameter int LOCK_RUN = 8,
  parameter int LOSS     = 12
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              toggled,
  output logic                              locked,
  output logic                              hit,
  output mdec_tick_t                        tick,
  output logic [$clog2(OSR+LOSS+1)-1:0]     phase_cnt
);

  localparam int CW       = $clog2(OSR + LOSS + 1);
  localparam int RW       = $clog2(LOCK_RUN + 1);
  localparam int LIMIT    = OSR + LOSS;
  localparam int WIN_LO   = OSR - TOL;
  localparam int WIN_HI   = OSR + TOL;
  localparam int SAMPLE_AT = OSR / 4;

  // cnt_q: samples elapsed since the last accepted centre transition.
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] run_q;
  logic          lock_q;
  logic          in_win;
  logic          drop;

  assign in_win = (cnt_q >= CW'(WIN_LO)) && (cnt_q <= CW'(WIN_HI));
  assign hit    = toggled && in_win && (lock_q || (run_q != '0));
  assign drop   = lock_q && !hit && (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (lock_q) begin
      if (hit) begin
        cnt_q <= CW'(1);
      end else if (drop) begin
        lock_q <= 1'b0;
        run_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (toggled) begin
        cnt_q <= CW'(1);
        if (hit) begin
          if (run_q == RW'(LOCK_RUN - 1)) begin
            lock_q <= 1'b1;
            run_q  <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= RW'(1);
        end
      end else if (cnt_q != CW'(LIMIT)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign locked      = lock_q;
  assign tick.sample = lock_q && (cnt_q == CW'(SAMPLE_AT));
  assign tick.drop   = drop;
  assign phase_cnt   = cnt_q;

endmodule

// File: rtl/mdec_frame.sv
module mdec_frame
  import mdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mdec_tick_t tick,
  input  logic       level,
  output logic       bit_stb,
  output logic       bit_val,
  output logic       inverted
);

  mdec_frame_t state_q;
  logic        have_prev_q;
  logic        prev_q;
  logic        inv_q;

  always_ff @(posedge clk) begin
    if (rst || tick.drop) begin
      state_q     <= FR_PREAMBLE;
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
      inv_q       <= 1'b0;
    end else if (tick.sample) begin
      case (state_q)
        FR_PREAMBLE: begin
          prev_q      <= level;
          have_prev_q <= 1'b1;
          if (have_prev_q && (level == prev_q)) begin
            state_q <= FR_PAYLOAD;
            inv_q   <= ~level;
          end
        end
        default: state_q <= FR_PAYLOAD;
      endcase
    end
  end

  assign bit_stb  = tick.sample && (state_q == FR_PAYLOAD);
  assign bit_val  = level ^ inv_q;
  assign inverted = inv_q;

endmodule

// File: rtl/mdec_outreg.sv
module mdec_outreg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
  import mdec_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int TOL      = 1,
  parameter int LOCK_RUN = 8,
  parameter int LOSS     = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit,
  output logic locked,
  output logic inverted
);

  localparam int CW    = $clog2(OSR + LOSS + 1);
  localparam int LIMIT = OSR + LOSS;

  logic          level;
  logic          toggled;
  logic          mid_hit;
  mdec_tick_t    tick;
  logic [CW-1:0] phase_cnt;
  logic          bit_stb;
  logic          bit_val;

  mdec_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .line_in (line_in),
    .level   (level),
    .toggled (toggled)
  );

  mdec_phase #(
    .OSR      (OSR),
    .TOL      (TOL),
    .LOCK_RUN (LOCK_RUN),
    .LOSS     (LOSS)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .toggled   (toggled),
    .locked    (locked),
    .hit       (mid_hit),
    .tick      (tick),
    .phase_cnt (phase_cnt)
  );

  mdec_frame u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .level    (level),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .inverted (inverted)
  );

  mdec_outreg #(.W(1)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (bit_stb),
    .din   (bit_val),
    .ready (out_ready),
    .valid (out_valid),
    .dout  (out_bit)
  );

endmodule

// File: rtl/mdec_rx_chk.sv
module mdec_rx_chk #(
  parameter int CW    = 5,
  parameter int LIMIT = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_bit,
  input logic          locked,
  input logic          inverted,
  input logic          mid_hit,
  input logic [CW-1:0] phase_cnt
);

  // R8: a held bit stays put while the sink stalls
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R10: no new output bit unless phase lock was held
  a_r10_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(locked));

  // R5 / R7: polarity flag never outlives lock
  a_r5_inv_within_lock: assert property (@(posedge clk) disable iff (rst)
    inverted |-> locked);

  // R7: lock falls only once the loss window has fully elapsed
  a_r7_drop_at_limit: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(phase_cnt) == CW'(LIMIT)));

  // R1: lock is gained only on an accepted centre transition
  a_r1_lock_on_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(mid_hit));

endmodule

bind mdec_rx mdec_rx_chk #(.CW(CW), .LIMIT(LIMIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .locked    (locked),
  .inverted  (inverted),
  .mid_hit   (mid_hit),
  .phase_cnt (phase_cnt)
);

// File: tb/mdec_rx_test.sv
module mdec_rx_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_bit, locked, inverted;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdec_rx uut (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .locked    (locked),
    .inverted  (inverted)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit exp_bits [0:63];
  int exp_n;
  bit got_bits [0:127];
  int got_n = 0;
  bit saw_lock = 1'b0;
  bit stalled_q = 1'b0;
  bit stalled_bit = 1'b0;
  int low_run = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Sink: random back-pressure (never more than 3 low cycles), capture, hold check.
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        out_ready = 1'b0;
        stalled_q = 1'b0;
        continue;
      end
      if (stalled_q)
        check(out_valid && (out_bit == stalled_bit), "R8 held bit during stall",
              {out_valid, out_bit}, {1'b1, stalled_bit});
      if (low_run >= 3 || $urandom_range(3) != 0) begin
        out_ready = 1'b1;
        low_run = 0;
      end else begin
        out_ready = 1'b0;
        low_run++;
      end
      #1;
      if (locked) saw_lock = 1'b1;
      if (out_valid && out_ready && got_n < 128) begin
        got_bits[got_n] = out_bit;
        got_n++;
      end
      stalled_q   = out_valid && !out_ready;
      stalled_bit = out_bit;
    end
  end

  // Expected line halves: normal sense codes b as (~b, b); swapped line XORs both.
  function automatic bit half_level(input bit b, input bit second, input bit pol);
    return (second ? b : ~b) ^ pol;
  endfunction

  task automatic idle(input bit lvl, input int n);
    line_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit pol, input int spb);
    int h;
    h = spb / 2;
    line_in = half_level(b, 1'b0, pol);
    repeat (h) @(negedge clk);
    line_in = half_level(b, 1'b1, pol);
    repeat (spb - h) @(negedge clk);
  endtask

  task automatic run_frame(input string tag, input int npre, input bit pol, input int ndata,
                           input int spb, input bit term, input bit expect_lock);
    got_n    = 0;
    saw_lock = 1'b0;
    exp_n    = 0;
    idle(1'($urandom_range(1)), 24);
    for (int i = 0; i < npre; i++) send_bit(1'(i % 2), pol, spb);
    if (term) send_bit(1'b1, pol, spb);
    for (int i = 0; i < ndata; i++) begin
      exp_bits[i] = 1'($urandom_range(1));
      send_bit(exp_bits[i], pol, spb);
    end
    exp_n = ndata;
    if (expect_lock) begin
      check(locked == 1'b1, {"R7 lock held through payload ", tag}, locked, 1);
      check(inverted == pol, {"R5 polarity flag ", tag}, inverted, pol);
    end
    idle(1'($urandom_range(1)), 40);
    check(!locked && !inverted, {"R7 flags cleared after silence ", tag},
          {locked, inverted}, 0);
    if (expect_lock) begin
      check(saw_lock, {"R1 lock acquired ", tag}, saw_lock, 1);
      check(got_n == exp_n, {"R4 payload bit count ", tag}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
        check(got_bits[i] == exp_bits[i], {"R3 R6 payload bit value ", tag},
              got_bits[i], exp_bits[i]);
    end else begin
      check(!saw_lock, {"R1 no lock expected ", tag}, saw_lock, 0);
      check(got_n == 0, {"R10 no output without lock ", tag}, got_n, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(!locked && !inverted && !out_valid, "R9 reset state",
          {locked, inverted, out_valid}, 0);
    rst = 1'b0;

    run_frame("normal", 16, 1'b0, 24, 8, 1'b1, 1'b1);
    run_frame("swapped", 16, 1'b1, 24, 8, 1'b1, 1'b1);
    run_frame("min preamble", 8, 1'b0, 16, 8, 1'b1, 1'b1);
    run_frame("min preamble swapped", 8, 1'b1, 16, 8, 1'b1, 1'b1);
    run_frame("R2 slow 9", 16, 1'b0, 24, 9, 1'b1, 1'b1);
    run_frame("R2 fast 7", 16, 1'b1, 24, 7, 1'b1, 1'b1);
    run_frame("R1 seven bits", 7, 1'b0, 0, 8, 1'b0, 1'b0);
    run_frame("R1 spacing 10", 16, 1'b0, 0, 10, 1'b0, 1'b0);
    run_frame("R1 spacing 6", 16, 1'b1, 0, 6, 1'b0, 1'b0);

    for (int k = 0; k < 10; k++)
      run_frame("random", 8 + 2 * int'($urandom_range(6)), 1'($urandom_range(1)),
                8 + int'($urandom_range(32)), 7 + int'($urandom_range(2)), 1'b1, 1'b1);

    // R9: reset in the middle of a swapped-polarity payload
    idle(1'b0, 24);
    for (int i = 0; i < 12; i++) send_bit(1'(i % 2), 1'b1, 8);
    send_bit(1'b1, 1'b1, 8);
    for (int i = 0; i < 4; i++) send_bit(1'($urandom_range(1)), 1'b1, 8);
    check(inverted == 1'b1, "R5 swapped flag before reset", inverted, 1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!locked && !inverted && !out_valid, "R9 mid-frame reset",
          {locked, inverted, out_valid}, 0);
    rst = 1'b0;
    run_frame("after reset", 14, 1'b0, 20, 8, 1'b1, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule